// File: doc/BRIEF.md
# Per-Class Virtual-Channel Credit Sender

This block sits on the transmit side of a packet link and decides, cycle by cycle, which waiting packet may leave and on which virtual network. Six message classes share the link. Each class has its own credit counter on two dedicated networks, and all classes draw from one shared adaptive pool. A dedicated credit pays for a whole packet. The shared pool pays one credit per flit.

Each class shows at most one head packet, with its length in flits. The block picks one eligible class per cycle in round-robin order. It prefers the shared pool when the pool covers the whole packet. If the pool is short, it falls back to the first dedicated network of that class, then to the second. The grant is combinational, so the requester can treat it as an accept strobe and advance its head on the same edge.

Credit counts and their ceilings are loaded by an initialization strobe. Credit returns decoded from reverse traffic add to one counter per cycle. A return that would lift a counter above its loaded ceiling clamps the counter and sets a sticky error flag.

Top module: `vc_credit_sender`

## Requirements
- R1: After reset every counter and ceiling is zero, `cred_err` is 0, and no grant is given until credits are loaded.
- R2: While `init_load` is high, no grant is given. On that edge every counter and its ceiling take the init values: `init_vn0`/`init_vn1` slice c (CNT_W bits at c*CNT_W) for class c, and `init_pool` for the shared pool.
- R3: A request of class c with length L is granted on network code 2 (shared) when the pool holds at least L. The pool then drops by L.
- R4: If the pool holds less than L, the grant uses code 0 when class c has a network-0 credit, and code 1 otherwise. The chosen counter drops by one. With no grant, `gnt_vn` reads 3.
- R5: A class with no network-0 credit, no network-1 credit and a pool below its length gets no grant, however long it waits.
- R6: A return (`ret_valid`, network `ret_vn`, class `ret_cls` (0 snoop, 1 home, 2 non-data response, 3 data response, 4 non-coherent standard, 5 non-coherent bypass), amount `ret_amt`) adds to that counter on the next edge. `ret_cls` is ignored for the pool. A debit and a return on the same counter in one cycle both apply.
- R7: If a return would raise a counter above its ceiling, the counter takes the ceiling value and `cred_err` sets. `cred_err` stays set until reset.
- R8: At most one class is granted per cycle, and only a requesting one. The search starts at the class after the last one granted, with class 0 first after reset.
- R9: The home class (class 1) has a single in-order head. A blocked home head gets no grant, and so no later home packet can pass it. Once its credit returns, that head is the next home grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_load | input | 1 | Load all counters and ceilings |
| init_vn0 | input | NUM_CLS*CNT_W | Network-0 credits per class |
| init_vn1 | input | NUM_CLS*CNT_W | Network-1 credits per class |
| init_pool | input | POOL_W | Shared pool flit credits |
| req_valid | input | NUM_CLS | Head packet waiting, per class |
| req_len | input | NUM_CLS*LEN_W | Head packet length in flits, per class |
| gnt | output | NUM_CLS | One-hot grant |
| gnt_vn | output | 2 | Network of the grant (0, 1, 2 shared, 3 none) |
| ret_valid | input | 1 | Credit return present |
| ret_vn | input | 2 | Network of the return |
| ret_cls | input | 3 | Class of the return |
| ret_amt | input | POOL_W | Credits returned |
| cred_err | output | 1 | Sticky return overflow flag |

## Verification
The assertions check, on every cycle, the properties that can be seen at the ports alone. A grant is one-hot and only goes to a requesting class. Nothing is granted during a load. The network code agrees with whether a grant was given. The error flag never clears. The bench's scenarios cover the parts that depend on the hidden counter values: choosing the shared pool over a dedicated network by flit length, falling back between the dedicated networks, starvation when credits run out, debits and returns landing together, clamping at the ceiling, the round-robin rotation, and the home head being held back.

// File: rtl/vc_credit_pkg.sv
package vc_credit_pkg;
  typedef enum logic [1:0] {
    VN_DED0   = 2'd0,
    VN_DED1   = 2'd1,
    VN_SHARED = 2'd2,
    VN_NONE   = 2'd3
  } vn_e;

  localparam int unsigned CLS_HOME = 1;
endpackage

// File: rtl/vc_credit_ctr.sv
module vc_credit_ctr #(
  parameter int unsigned W  = 4,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          debit,
  input  logic [AW-1:0] debit_amt,
  input  logic          ret,
  input  logic [AW-1:0] ret_amt,
  output logic [W-1:0]  count,
  output logic          ovf
);
  localparam int unsigned SW = ((W > AW) ? W : AW) + 1;

  logic [W-1:0]  ceil_q;
  logic [W-1:0]  count_d, ceil_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum     = SW'(count) + (ret ? SW'(ret_amt) : '0) - (debit ? SW'(debit_amt) : '0);
    ovf     = 1'b0;
    ceil_d  = ceil_q;
    count_d = count;
    if (load) begin
      count_d = load_val;
      ceil_d  = load_val;
    end else if (sum > SW'(ceil_q)) begin
      count_d = ceil_q;
      ovf     = 1'b1;
    end else begin
      count_d = W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ceil_q <= '0;
    end else if (load || debit || ret) begin
      count  <= count_d;
      ceil_q <= ceil_d;
    end
  end
endmodule

// File: rtl/vc_rr_arb.sv
module vc_rr_arb #(
  parameter int unsigned N     = 6,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 1; k <= int'(N); k++) begin
      int j;
      j = (int'(ptr_q) + k) % int'(N);
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IDX_W'(N - 1);
    else if (any) ptr_q <= idx;
  end
endmodule

// File: rtl/vc_credit_sender.sv
module vc_credit_sender
  import vc_credit_pkg::*;
#(
  parameter int unsigned NUM_CLS = 6,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned POOL_W  = 6,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned CLS_W   = $clog2(NUM_CLS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_load,
  input  logic [NUM_CLS*CNT_W-1:0] init_vn0,
  input  logic [NUM_CLS*CNT_W-1:0] init_vn1,
  input  logic [POOL_W-1:0]        init_pool,
  input  logic [NUM_CLS-1:0]       req_valid,
  input  logic [NUM_CLS*LEN_W-1:0] req_len,
  output logic [NUM_CLS-1:0]       gnt,
  output logic [1:0]               gnt_vn,
  input  logic                     ret_valid,
  input  logic [1:0]               ret_vn,
  input  logic [CLS_W-1:0]         ret_cls,
  input  logic [POOL_W-1:0]        ret_amt,
  output logic                     cred_err
);
  localparam int unsigned IDX_W = $clog2(NUM_CLS);

  logic [CNT_W-1:0]  cnt0 [NUM_CLS];
  logic [CNT_W-1:0]  cnt1 [NUM_CLS];
  logic [POOL_W-1:0] pool;
  vn_e               sel_vn [NUM_CLS];
  logic [NUM_CLS-1:0] elig;
  logic [NUM_CLS-1:0] ovf0, ovf1;
  logic              ovf_pool;
  logic [IDX_W-1:0]  g_idx;
  logic              g_any;
  logic [POOL_W-1:0] g_len;
  logic              pool_debit, pool_ret;
  logic              err_d;

  generate
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      logic [POOL_W-1:0] len_c;
      logic ok_sh, ok0, ok1, ret_here;
      assign len_c    = POOL_W'(req_len[c*LEN_W +: LEN_W]);
      assign ok_sh    = (pool >= len_c);
      assign ok0      = (cnt0[c] != '0);
      assign ok1      = (cnt1[c] != '0);
      assign elig[c]  = req_valid[c] && !init_load && (ok_sh || ok0 || ok1);
      assign sel_vn[c] = ok_sh ? VN_SHARED : (ok0 ? VN_DED0 : VN_DED1);
      assign ret_here = ret_valid && (ret_cls == CLS_W'(c));

      vc_credit_ctr #(.W(CNT_W), .AW(POOL_W)) u_vn0 (
        .clk(clk), .rst_n(rst_n), .load(init_load),
        .load_val(init_vn0[c*CNT_W +: CNT_W]),
        .debit(gnt[c] && (sel_vn[c] == VN_DED0)), .debit_amt(POOL_W'(1)),
        .ret(ret_here && (ret_vn == VN_DED0)), .ret_amt(ret_amt),
        .count(cnt0[c]), .ovf(ovf0[c]));

      vc_credit_ctr #(.W(CNT_W), .AW(POOL_W)) u_vn1 (
        .clk(clk), .rst_n(rst_n), .load(init_load),
        .load_val(init_vn1[c*CNT_W +: CNT_W]),
        .debit(gnt[c] && (sel_vn[c] == VN_DED1)), .debit_amt(POOL_W'(1)),
        .ret(ret_here && (ret_vn == VN_DED1)), .ret_amt(ret_amt),
        .count(cnt1[c]), .ovf(ovf1[c]));
    end
  endgenerate

  vc_rr_arb #(.N(NUM_CLS), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .gnt(gnt), .idx(g_idx), .any(g_any));

  always_comb begin
    g_len      = POOL_W'(req_len[g_idx*LEN_W +: LEN_W]);
    gnt_vn     = g_any ? sel_vn[g_idx] : VN_NONE;
    pool_debit = g_any && (sel_vn[g_idx] == VN_SHARED);
    pool_ret   = ret_valid && (ret_vn == VN_SHARED);
  end

  vc_credit_ctr #(.W(POOL_W), .AW(POOL_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .load(init_load), .load_val(init_pool),
    .debit(pool_debit), .debit_amt(g_len),
    .ret(pool_ret), .ret_amt(ret_amt),
    .count(pool), .ovf(ovf_pool));

  always_comb err_d = cred_err || ovf_pool || (|ovf0) || (|ovf1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cred_err <= 1'b0;
    else        cred_err <= err_d;
  end
endmodule

// File: rtl/vc_credit_sender_chk.sv
module vc_credit_sender_chk #(
  parameter int unsigned NUM_CLS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_load,
  input logic [NUM_CLS-1:0] req_valid,
  input logic [NUM_CLS-1:0] gnt,
  input logic [1:0]         gnt_vn,
  input logic               cred_err
);
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req_valid) == '0);

  a_r2_quiet_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |-> (gnt == '0));

  a_r4_vn_code_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> (gnt_vn != 2'd3));

  a_r4_vn_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |-> (gnt_vn == 2'd3));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cred_err |=> cred_err);

  a_r1_clean_start: assert property (@(posedge clk)
    $rose(rst_n) |-> (gnt == '0 && !cred_err));
endmodule

bind vc_credit_sender vc_credit_sender_chk #(.NUM_CLS(NUM_CLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_load(init_load), .req_valid(req_valid),
  .gnt(gnt), .gnt_vn(gnt_vn), .cred_err(cred_err));

// File: tb/vc_credit_sender_test.sv
`timescale 1ns/1ps
module vc_credit_sender_test;
  localparam int NC = 6, CW = 4, PW = 6, LW = 4, SW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic init_load;
  logic [NC*CW-1:0] init_vn0, init_vn1;
  logic [PW-1:0] init_pool;
  logic [NC-1:0] req_valid;
  logic [NC*LW-1:0] req_len;
  logic [NC-1:0] gnt;
  logic [1:0] gnt_vn;
  logic ret_valid;
  logic [1:0] ret_vn;
  logic [SW-1:0] ret_cls;
  logic [PW-1:0] ret_amt;
  logic cred_err;

  int checks = 0, fails = 0;
  int m0[NC], m1[NC], x0[NC], x1[NC];
  int mp, xp, mptr;
  bit merr;
  int e_idx, e_vn;

  always #2.5 clk = ~clk;

  vc_credit_sender uut (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_vn0(init_vn0),
    .init_vn1(init_vn1), .init_pool(init_pool), .req_valid(req_valid),
    .req_len(req_len), .gnt(gnt), .gnt_vn(gnt_vn), .ret_valid(ret_valid),
    .ret_vn(ret_vn), .ret_cls(ret_cls), .ret_amt(ret_amt), .cred_err(cred_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int c);
    return int'(req_len[c*LW +: LW]);
  endfunction

  // Expected grant from the model state and current inputs
  task automatic predict();
    e_idx = -1; e_vn = 3;
    for (int k = 1; k <= NC; k++) begin
      int j;
      j = (mptr + k) % NC;
      if (e_idx < 0 && req_valid[j] && !init_load &&
          (mp >= len_of(j) || m0[j] != 0 || m1[j] != 0)) begin
        e_idx = j;
        e_vn = (mp >= len_of(j)) ? 2 : (m0[j] != 0 ? 0 : 1);
      end
    end
  endtask

  function automatic int apply(input int cur, input int dec, input int add, input int mx, inout bit err);
    int s;
    s = cur - dec + add;
    if (s > mx) begin err = 1'b1; return mx; end
    return s;
  endfunction

  // One cycle: inputs are already driven; check, update model, advance
  task automatic step();
    int exp_g;
    #1;
    predict();
    exp_g = (e_idx < 0) ? 0 : (1 << e_idx);
    chk(int'(gnt) == exp_g, "R8 grant vector", int'(gnt), exp_g);
    chk(int'(gnt_vn) == e_vn, (e_vn == 2) ? "R3 network" : "R4 network", int'(gnt_vn), e_vn);
    if (init_load) begin
      for (int c = 0; c < NC; c++) begin
        m0[c] = int'(init_vn0[c*CW +: CW]); x0[c] = m0[c];
        m1[c] = int'(init_vn1[c*CW +: CW]); x1[c] = m1[c];
      end
      mp = int'(init_pool); xp = mp;
    end else begin
      for (int c = 0; c < NC; c++) begin
        int d0, d1, a0, a1;
        d0 = (e_idx == c && e_vn == 0) ? 1 : 0;
        d1 = (e_idx == c && e_vn == 1) ? 1 : 0;
        a0 = (ret_valid && ret_vn == 0 && int'(ret_cls) == c) ? int'(ret_amt) : 0;
        a1 = (ret_valid && ret_vn == 1 && int'(ret_cls) == c) ? int'(ret_amt) : 0;
        if (d0 || a0) m0[c] = apply(m0[c], d0, a0, x0[c], merr);
        if (d1 || a1) m1[c] = apply(m1[c], d1, a1, x1[c], merr);
      end
      begin
        int dp, ap;
        dp = (e_vn == 2) ? len_of(e_idx) : 0;
        ap = (ret_valid && ret_vn == 2) ? int'(ret_amt) : 0;
        if (dp || ap) mp = apply(mp, dp, ap, xp, merr);
      end
    end
    if (e_idx >= 0) mptr = e_idx;
    @(posedge clk);
    @(negedge clk);
    chk(cred_err == merr, "R7 error flag", int'(cred_err), int'(merr));
  endtask

  task automatic idle_inputs();
    init_load = 0; req_valid = '0; req_len = '0; ret_valid = 0;
    ret_vn = 0; ret_cls = 0; ret_amt = 0;
  endtask

  task automatic set_len(input int c, input int l);
    req_len[c*LW +: LW] = LW'(l);
  endtask

  task automatic load(input int v0, input int v1, input int p);
    idle_inputs();
    init_load = 1;
    for (int c = 0; c < NC; c++) begin
      init_vn0[c*CW +: CW] = CW'(v0 < 0 ? $urandom_range(0, 3) : v0);
      init_vn1[c*CW +: CW] = CW'(v1 < 0 ? $urandom_range(0, 3) : v1);
    end
    init_pool = PW'(p);
    req_valid = '1;
    for (int c = 0; c < NC; c++) set_len(c, 1);
    #1;
    chk(gnt == '0, "R2 no grant during load", int'(gnt), 0);
    step();
    idle_inputs();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 0; idle_inputs(); init_vn0 = '0; init_vn1 = '0; init_pool = '0;
    for (int c = 0; c < NC; c++) begin m0[c] = 0; m1[c] = 0; x0[c] = 0; x1[c] = 0; end
    mp = 0; xp = 0; mptr = NC - 1; merr = 0;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && cred_err == 0, "R1 reset outputs", int'(gnt), 0);
    rst_n = 1;
    // R1: nothing granted before a load
    req_valid = '1;
    for (int c = 0; c < NC; c++) set_len(c, 1);
    #1;
    chk(gnt == '0, "R1 no credits after reset", int'(gnt), 0);
    step();

    // R3/R4/R5/R6: directed fallback on the home class
    load(1, 1, 4);
    req_valid = 6'b000010; set_len(1, 3);
    step();                       // shared pool, pool 4 -> 1
    set_len(1, 5);
    step();                       // pool short -> network 0
    step();                       // network 1
    #1;
    chk(gnt == '0, "R5 exhausted class waits", int'(gnt), 0);
    chk(gnt == '0, "R9 blocked home head not passed", int'(gnt), 0);
    step();
    ret_valid = 1; ret_vn = 2'd1; ret_cls = 3'd1; ret_amt = 6'd1;
    step();                       // return lands on this edge
    ret_valid = 0;
    #1;
    chk(gnt == 6'b000010 && gnt_vn == 2'd1, "R6 returned credit usable", int'(gnt_vn), 1);
    chk(gnt == 6'b000010, "R9 home head is next grant", int'(gnt), 2);
    step();
    // R6: debit and return on the same counter in one cycle
    ret_valid = 1; ret_vn = 2'd2; ret_amt = 6'd3; set_len(1, 1);
    step();

    // R8: round robin with every class ready
    load(3, 3, 0);
    req_valid = '1;
    for (int i = 0; i < 12; i++) step();

    // Constrained random
    for (int blk = 0; blk < 6; blk++) begin
      load(-1, -1, $urandom_range(8, 40));
      for (int i = 0; i < 500; i++) begin
        req_valid = NC'($urandom());
        for (int c = 0; c < NC; c++) set_len(c, $urandom_range(1, 8));
        ret_valid = 0;
        if ($urandom_range(0, 2) == 0) begin
          int v, c, room;
          v = $urandom_range(0, 2); c = $urandom_range(0, NC - 1);
          room = (v == 0) ? x0[c] - m0[c] : (v == 1) ? x1[c] - m1[c] : xp - mp;
          if (room > 0) begin
            ret_valid = 1; ret_vn = 2'(v); ret_cls = SW'(c);
            ret_amt = PW'($urandom_range(1, room));
          end
        end
        step();
      end
    end

    // R7: overflowing return clamps and sets the sticky flag
    load(2, 2, 10);
    ret_valid = 1; ret_vn = 2'd0; ret_cls = 3'd4; ret_amt = 6'd5;
    step();
    ret_valid = 0;
    // drain class 4 network 0: pool covers nothing of length 15 after it empties
    req_valid = 6'b010000; set_len(4, 15);
    step(); step(); step(); step();
    #1;
    chk(gnt == '0, "R7 clamped count stayed at ceiling", int'(gnt), 0);
    idle_inputs();
    step(); step();
    chk(cred_err == 1'b1, "R7 flag sticky", int'(cred_err), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule